// File: doc/BRIEF.md
# Quasi-Bidirectional Port Controller

This block is the digital control for one 8-bit general-purpose I/O port of a microcontroller. It holds the port's output latch. The CPU can load the latch as a whole byte, or change one bit of it in a read-modify-write step. Two read values are always available: the latch contents and the pin levels, where the pin levels are sampled through a two-stage synchronizer.

The block also decides what the pad should drive. In a normal cycle the latch is combined with the peripheral's alternate output. During an external memory cycle the bus value takes its place. From that value the block produces per-bit on/off enables for the pad's transistors:

- the pull-down;
- a strong pull-up that fires as a short boost;
- a pull-up held on by feedback from the pin;
- a very weak pull-up.

A mode input chooses between two kinds of port. In quasi-bidirectional mode the pull-ups are used. In true bidirectional open-drain mode the pull-ups are off and the strong pull-up helps only during bus cycles. A per-bit analog select turns off every pull-up of that bit.

Top module: `port_qb_ctrl`

## Requirements
- R1: During and after reset every latch bit is 1, both synchronizer stages hold 0, and no boost is active until a latch bit rises.
- R2: A byte write (`wr_en`) loads `wr_data` into the latch at the clock edge. When a byte write and a bit operation happen in the same cycle, the byte write wins.
- R3: A bit operation (`bit_wr_en`, with `wr_en` low) reads all latch bits, replaces only bit number `bit_idx` (0 = LSB) with `bit_val`, and writes the whole byte back at the edge.
- R4: `rd_latch_data` always returns the latch contents, whatever the pins show. `rd_pin_data` returns `pin_in` delayed by two clock edges.
- R5: The effective output is `bus_data` when `bus_cycle` is 1, and latch AND `alt_out` otherwise. `pd_en` is the inverse of the effective output, bit by bit.
- R6: In quasi mode (`mode_od` = 0), a latch bit that goes from 0 to 1 drives its `pu_boost_en` bit high for exactly two clock cycles, starting in the first cycle the latch reads 1. The boost is cut short if that latch bit returns to 0, and it is shown only while the effective output bit is 1.
- R7: In quasi mode `pu_hold_en` equals the synchronized pin level.
- R8: In quasi mode `pu_weak_en` is 1 exactly where `pd_en` is 0.
- R9: In open-drain mode (`mode_od` = 1), `pu_hold_en` and `pu_weak_en` are 0. `pu_boost_en` is `bus_data` during a bus cycle and 0 otherwise.
- R10: For a bit with `analog_sel` = 1, `pu_boost_en`, `pu_hold_en` and `pu_weak_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low reset |
| mode_od | input | 1 | 1 = open-drain bidirectional, 0 = quasi-bidirectional |
| bus_cycle | input | 1 | External memory cycle in progress |
| bus_data | input | 8 | Address/data value to drive during a bus cycle |
| alt_out | input | 8 | Alternate peripheral output per bit |
| analog_sel | input | 8 | Per-bit analog input select |
| pin_in | input | 8 | Raw pin levels |
| wr_en | input | 1 | Byte write to latch |
| wr_data | input | 8 | Byte write value |
| bit_wr_en | input | 1 | Single-bit read-modify-write |
| bit_idx | input | 3 | Bit addressed by the bit operation |
| bit_val | input | 1 | New value of the addressed bit |
| rd_latch_data | output | 8 | Latch read value |
| rd_pin_data | output | 8 | Synchronized pin read value |
| pd_en | output | 8 | Pull-down enable |
| pu_boost_en | output | 8 | Strong pull-up boost enable |
| pu_hold_en | output | 8 | Pin-feedback pull-up enable |
| pu_weak_en | output | 8 | Very weak pull-up enable |

## Verification
A corrupted latch bit shows on `rd_latch_data` and `pd_en` in the cycle after the faulty edge. This is so because both are driven combinationally from the latch register. A boost counter that loads the wrong value or fails to clear shows as a pulse of one, three or more cycles on `pu_boost_en`, so the bench samples that port on each cycle after a rising write. A synchronizer with the wrong depth shows as `rd_pin_data` and `pu_hold_en` changing one edge early or late, so the bench checks the value after one edge and again after two.

// File: rtl/port_qb_pkg.sv
package port_qb_pkg;

    typedef enum logic {
        DRV_LATCH_ALT = 1'b0,
        DRV_BUS       = 1'b1
    } drive_src_e;

    typedef enum logic {
        MODE_QUASI = 1'b0,
        MODE_OPEN  = 1'b1
    } port_mode_e;

endpackage

// File: rtl/port_qb_latch.sv
module port_qb_latch #(
    parameter int WIDTH = 8,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [IW-1:0]    bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] lat_d
);
    typedef struct packed {
        logic [WIDTH-1:0] lat;
    } lat_state_t;

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.lat = wr_data;
        end else if (bit_wr_en) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (IW'(i) == bit_idx) begin
                    st_d.lat[i] = bit_val;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lat <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lat_q = st_q.lat;
    assign lat_d = st_d.lat;
endmodule

// File: rtl/port_qb_sync.sv
module port_qb_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.s2;
endmodule

// File: rtl/port_qb_boost.sv
module port_qb_boost #(
    parameter int WIDTH        = 8,
    parameter int BOOST_CYCLES = 2,
    localparam int CW = $clog2(BOOST_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] lat_d,
    output logic [WIDTH-1:0] pulse
);
    typedef struct packed {
        logic [WIDTH-1:0][CW-1:0] cnt;
    } boost_state_t;

    boost_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            if (!lat_d[i]) begin
                st_d.cnt[i] = '0;
            end else if (!lat_q[i]) begin
                st_d.cnt[i] = CW'(BOOST_CYCLES);
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_pulse
        assign pulse[g] = (st_q.cnt[g] != '0);
    end
endmodule

// File: rtl/port_qb_ctrl.sv
module port_qb_ctrl
    import port_qb_pkg::*;
#(
    parameter int WIDTH        = 8,
    parameter int BOOST_CYCLES = 2,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_od,
    input  logic             bus_cycle,
    input  logic [WIDTH-1:0] bus_data,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] analog_sel,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [IW-1:0]    bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] rd_latch_data,
    output logic [WIDTH-1:0] rd_pin_data,
    output logic [WIDTH-1:0] pd_en,
    output logic [WIDTH-1:0] pu_boost_en,
    output logic [WIDTH-1:0] pu_hold_en,
    output logic [WIDTH-1:0] pu_weak_en
);
    logic [WIDTH-1:0] lat_q, lat_d, pin_sync, pulse, eff_out;
    drive_src_e       src;
    port_mode_e       mode;

    port_qb_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .lat_q(lat_q), .lat_d(lat_d)
    );

    port_qb_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    port_qb_boost #(.WIDTH(WIDTH), .BOOST_CYCLES(BOOST_CYCLES)) u_boost (
        .clk(clk), .rst_n(rst_n), .lat_q(lat_q), .lat_d(lat_d), .pulse(pulse)
    );

    always_comb begin
        src  = bus_cycle ? DRV_BUS : DRV_LATCH_ALT;
        mode = mode_od ? MODE_OPEN : MODE_QUASI;
        unique case (src)
            DRV_BUS:       eff_out = bus_data;
            default:       eff_out = lat_q & alt_out;
        endcase
        pd_en = ~eff_out;
        if (mode == MODE_OPEN) begin
            pu_boost_en = (src == DRV_BUS) ? (bus_data & ~analog_sel) : '0;
            pu_hold_en  = '0;
            pu_weak_en  = '0;
        end else begin
            pu_boost_en = pulse & eff_out & ~analog_sel;
            pu_hold_en  = pin_sync & ~analog_sel;
            pu_weak_en  = eff_out & ~analog_sel;
        end
    end

    assign rd_latch_data = lat_q;
    assign rd_pin_data   = pin_sync;
endmodule

// File: rtl/port_qb_ctrl_chk.sv
module port_qb_ctrl_chk #(
    parameter int WIDTH = 8,
    localparam int IW = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_od,
    input logic             bus_cycle,
    input logic [WIDTH-1:0] analog_sel,
    input logic             wr_en,
    input logic             bit_wr_en,
    input logic [IW-1:0]    bit_idx,
    input logic             bit_val,
    input logic [WIDTH-1:0] rd_latch_data,
    input logic [WIDTH-1:0] pd_en,
    input logic [WIDTH-1:0] pu_boost_en,
    input logic [WIDTH-1:0] pu_hold_en,
    input logic [WIDTH-1:0] pu_weak_en
);
    AST_RESET_LATCH_ONES: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_latch_data == '1)); // R1

    AST_BIT_OP_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && !wr_en) |=>
        (((rd_latch_data ^ $past(rd_latch_data)) & ~(WIDTH'(1) << $past(bit_idx))) == '0)); // R3

    AST_BIT_OP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_wr_en && !wr_en) |=> (rd_latch_data[$past(bit_idx)] == $past(bit_val))); // R3

    AST_BOOST_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_od && !bus_cycle) |->
        ((rd_latch_data & ~$past(rd_latch_data) & ~pd_en & ~analog_sel & ~pu_boost_en) == '0)); // R6

    AST_NO_BOOST_AGAINST_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_boost_en & pd_en) == '0); // R6

    AST_OPEN_DRAIN_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_od |-> ((pu_hold_en | pu_weak_en) == '0)); // R9

    AST_ANALOG_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        ((pu_boost_en | pu_hold_en | pu_weak_en) & analog_sel) == '0); // R10
endmodule

bind port_qb_ctrl port_qb_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_od(mode_od), .bus_cycle(bus_cycle),
    .analog_sel(analog_sel), .wr_en(wr_en), .bit_wr_en(bit_wr_en),
    .bit_idx(bit_idx), .bit_val(bit_val), .rd_latch_data(rd_latch_data),
    .pd_en(pd_en), .pu_boost_en(pu_boost_en), .pu_hold_en(pu_hold_en),
    .pu_weak_en(pu_weak_en)
);

// File: tb/port_qb_ctrl_tb.sv
module port_qb_ctrl_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_od = 1'b0, bus_cycle = 1'b0;
    logic [W-1:0] bus_data = '0, alt_out = '1, analog_sel = '0, pin_in = '0;
    logic         wr_en = 1'b0, bit_wr_en = 1'b0, bit_val = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   bit_idx = '0;
    logic [W-1:0] rd_latch_data, rd_pin_data, pd_en, pu_boost_en, pu_hold_en, pu_weak_en;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    port_qb_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_od(mode_od), .bus_cycle(bus_cycle),
        .bus_data(bus_data), .alt_out(alt_out), .analog_sel(analog_sel),
        .pin_in(pin_in), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .rd_latch_data(rd_latch_data), .rd_pin_data(rd_pin_data),
        .pd_en(pd_en), .pu_boost_en(pu_boost_en), .pu_hold_en(pu_hold_en),
        .pu_weak_en(pu_weak_en)
    );

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] alt;
        logic         bus;
        logic [W-1:0] bd;
        logic         od;
        logic [W-1:0] an;
        logic [W-1:0] pin;
        logic [W-1:0] e_pd;
        logic [W-1:0] e_weak;
        logic [W-1:0] e_boost;
        logic [W-1:0] e_hold;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h81, 8'h00, 8'hFF, 8'h00, 8'h81},
        '{8'h0F, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00, 8'h0F, 8'hF0, 8'h0F, 8'h00, 8'h0F},
        '{8'hFF, 8'h3C, 1'b0, 8'h00, 1'b0, 8'h00, 8'h3C, 8'hC3, 8'h3C, 8'h00, 8'h3C},
        '{8'hA5, 8'hFF, 1'b1, 8'h5A, 1'b0, 8'h00, 8'h5A, 8'hA5, 8'h5A, 8'h00, 8'h5A},
        '{8'hFF, 8'hFF, 1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h00, 8'hFF, 1'b1, 8'h96, 1'b1, 8'h00, 8'h96, 8'h69, 8'h00, 8'h96, 8'h00},
        '{8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0, 8'hF0, 8'hFF, 8'h00, 8'h0F, 8'h00, 8'h0F}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic byte_wr(input logic [W-1:0] v);
        wr_en = 1'b1;
        wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic bit_op(input logic [2:0] idx, input logic v);
        bit_wr_en = 1'b1;
        bit_idx = idx;
        bit_val = v;
        tick();
        bit_wr_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        pin_in = 8'h5A;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1 latch in reset", rd_latch_data, 8'hFF);
        chk("R1 sync in reset", rd_pin_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 latch after reset", rd_latch_data, 8'hFF);
        chk("R1 no boost after reset", pu_boost_en, 8'h00);

        // Table walk: R5 R7 R8 R9 R10
        for (int k = 0; k < 7; k++) begin
            alt_out = TBL[k].alt; bus_cycle = TBL[k].bus; bus_data = TBL[k].bd;
            mode_od = TBL[k].od; analog_sel = TBL[k].an; pin_in = TBL[k].pin;
            byte_wr(TBL[k].lat);
            repeat (3) tick();
            chk("R2 table latch", rd_latch_data, TBL[k].lat);
            chk("R4 table pin read", rd_pin_data, TBL[k].pin);
            chk("R5 table pd_en", pd_en, TBL[k].e_pd);
            chk("R8 table weak", pu_weak_en, TBL[k].e_weak);
            chk("R9 table boost", pu_boost_en, TBL[k].e_boost);
            chk("R7 table hold", pu_hold_en, TBL[k].e_hold);
        end
        mode_od = 1'b0; bus_cycle = 1'b0; alt_out = '1; analog_sel = '0; bus_data = '0;

        // R6: full pulse of exactly two cycles
        byte_wr(8'h00);
        tick();
        byte_wr(8'hFF);
        chk("R6 boost cycle 1", pu_boost_en, 8'hFF);
        tick();
        chk("R6 boost cycle 2", pu_boost_en, 8'hFF);
        tick();
        chk("R6 boost over", pu_boost_en, 8'h00);

        // R6: only the bits that rose
        byte_wr(8'h0F);
        tick();
        byte_wr(8'hFF);
        chk("R6 partial rise", pu_boost_en, 8'hF0);
        repeat (2) tick();

        // R6: pulse cut short when latch falls
        byte_wr(8'h00);
        byte_wr(8'hFF);
        byte_wr(8'h00);
        chk("R6 cancel on fall", pu_boost_en, 8'h00);
        chk("R5 pd after fall", pd_en, 8'hFF);

        // R10: analog bits get no boost
        analog_sel = 8'h0F;
        byte_wr(8'hFF);
        chk("R10 analog masks boost", pu_boost_en, 8'hF0);
        analog_sel = '0;
        repeat (2) tick();

        // R9: open-drain mode, rising latch gives no boost
        mode_od = 1'b1;
        byte_wr(8'h00);
        byte_wr(8'hFF);
        chk("R9 no boost open drain", pu_boost_en, 8'h00);
        mode_od = 1'b0;
        repeat (2) tick();

        // R3 and R4: bit operations, latch read vs pin read
        pin_in = 8'h00;
        byte_wr(8'hA5);
        repeat (2) tick();
        chk("R4 latch read ignores pins", rd_latch_data, 8'hA5);
        chk("R4 pin read", rd_pin_data, 8'h00);
        bit_op(3'd1, 1'b1);
        chk("R3 set bit 1", rd_latch_data, 8'hA7);
        bit_op(3'd7, 1'b0);
        chk("R3 clear bit 7", rd_latch_data, 8'h27);
        bit_op(3'd3, 1'b1);
        chk("R3 set bit 3", rd_latch_data, 8'h2F);
        chk("R6 boost on bit op", pu_boost_en, 8'h08);

        // R2: byte write wins over bit op
        wr_en = 1'b1; wr_data = 8'h3C;
        bit_wr_en = 1'b1; bit_idx = 3'd0; bit_val = 1'b1;
        tick();
        wr_en = 1'b0; bit_wr_en = 1'b0;
        chk("R2 byte priority", rd_latch_data, 8'h3C);

        // R4 R7: two-edge synchronizer latency
        pin_in = 8'hC3;
        tick();
        chk("R4 pin after one edge", rd_pin_data, 8'h00);
        tick();
        chk("R4 pin after two edges", rd_pin_data, 8'hC3);
        chk("R7 hold follows pin", pu_hold_en, 8'hC3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule